// File: doc/BRIEF.md
# Interrupt Enable Register with Set/Clear Access

This block holds the 32-bit interrupt enable mask of a host controller and produces its single external interrupt line. Software never writes the mask directly: one register address sets every mask bit whose data bit is 1, and a second address clears every mask bit whose data bit is 1. A read at either address returns the same current mask.

Each enable bit below bit 31 pairs with the same-numbered bit of an incoming event vector. A source counts only when its enable bit and its event bit are both 1. Bit 31 is a global gate over the OR of all counted sources. A hardware input can force the global gate off, for example after a fatal fault. Bit 28 and bits 14..10 have no storage and always read 0.

Top module: `irq_mask_reg`

## Requirements
- R1: A write strobe at address 0x88 sets every writable mask bit whose data bit is 1. All other mask bits keep their value.
- R2: A write strobe at address 0x8C clears every writable mask bit whose data bit is 1. All other mask bits keep their value.
- R3: In the same cycle, the read data at address 0x88 and at address 0x8C both equal the current mask. Read data at any other address is 0.
- R4: Bit 28 and bits 14 through 10 always read 0, and set or clear writes do not change them.
- R5: A write strobe at any address other than 0x88 or 0x8C leaves the mask unchanged.
- R6: After reset, every mask bit is 0 and the interrupt output is low.
- R7: The interrupt output is registered. One cycle after the inputs, it equals mask bit 31 ANDed with the OR, over bits 30..0, of (mask AND event).
- R8: When mask bit 31 is 0, the interrupt output stays low whatever the other mask bits and event bits hold.
- R9: A pulse on the master-kill input clears mask bit 31 on the next edge. This takes priority over a set of bit 31 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data; bits that are 1 select mask bits |
| rdata_o | output | 32 | Combinational read data for addr_i |
| event_i | input | 32 | Interrupt event vector (bit 31 ignored) |
| master_kill_i | input | 1 | Hardware clear of the master enable |
| irq_o | output | 1 | Registered external interrupt |

## Verification
The bench keeps a behavioural copy of the mask and of the pending interrupt and compares both on every clock. It targets the corner cases below; a wrong design fails each one as stated:
- Back-to-back set and clear writes with overlapping patterns: a design that applies a plain write would destroy bits the data did not select.
- All-ones writes: a design with storage behind bit 28 or bits 14..10 would return 1s there.
- Master enable cleared while enabled events are pending: a design that leaks the OR past the gate would assert the interrupt.
- Master-kill in the same cycle as a set of bit 31: a design with the wrong priority would leave the master enable on.
- Writes to unmapped addresses: a design with loose address decode would change the mask.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;
  localparam int unsigned MASTER_BIT = 31;
  localparam logic [AW-1:0] SET_ADDR = 8'h88;
  localparam logic [AW-1:0] CLR_ADDR = 8'h8C;
  // bit 28 and 14..10 have no storage
  localparam logic [DW-1:0] IMPL_MASK = 32'hEFFF_83FF;

  typedef enum logic [1:0] {OP_NONE, OP_SET, OP_CLR} mask_op_e;
endpackage

// File: rtl/irq_mask_decode.sv
module irq_mask_decode
  import irq_mask_pkg::*;
(
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  output mask_op_e      op_o,
  output logic          rd_hit_o
);
  assign rd_hit_o = (addr_i == SET_ADDR) || (addr_i == CLR_ADDR);

  always_comb begin
    op_o = OP_NONE;
    if (wr_en_i) begin
      if (addr_i == SET_ADDR)      op_o = OP_SET;
      else if (addr_i == CLR_ADDR) op_o = OP_CLR;
    end
  end
endmodule

// File: rtl/irq_mask_store.sv
module irq_mask_store
  import irq_mask_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  mask_op_e      op_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          master_kill_i,
  output logic [DW-1:0] mask_o
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else if ((b == MASTER_BIT) && master_kill_i) q <= 1'b0;
        else if (op_i == OP_SET && wdata_i[b]) q <= 1'b1;
        else if (op_i == OP_CLR && wdata_i[b]) q <= 1'b0;
      end
      assign mask_o[b] = q;
    end else begin : g_rsvd
      assign mask_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_gen.sv
module irq_mask_gen
  import irq_mask_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] event_i,
  output logic          irq_o
);
  logic [MASTER_BIT-1:0] hit;
  logic                  irq_d;

  assign hit   = mask_i[MASTER_BIT-1:0] & event_i[MASTER_BIT-1:0];
  assign irq_d = mask_i[MASTER_BIT] & (|hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_d;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_mask_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] event_i,
  input  logic          master_kill_i,
  output logic          irq_o
);
  mask_op_e      op;
  logic          rd_hit;
  logic [DW-1:0] mask;

  irq_mask_decode u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .op_o    (op),
    .rd_hit_o(rd_hit)
  );

  irq_mask_store u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_i         (op),
    .wdata_i      (wdata_i),
    .master_kill_i(master_kill_i),
    .mask_o       (mask)
  );

  irq_mask_gen u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mask_i (mask),
    .event_i(event_i),
    .irq_o  (irq_o)
  );

  assign rdata_o = rd_hit ? mask : '0;
endmodule

// File: rtl/irq_mask_reg_chk.sv
module irq_mask_reg_chk
  import irq_mask_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] event_i,
  input logic          master_kill_i,
  input logic          irq_o
);
  a_r4_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~IMPL_MASK) == '0);

  a_r1_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == SET_ADDR && !master_kill_i) |=>
    (((rdata_o & IMPL_MASK & $past(wdata_i)) == (IMPL_MASK & $past(wdata_i)))
     || !(addr_i == SET_ADDR || addr_i == CLR_ADDR)));

  a_r8_master_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr_i == SET_ADDR) && !rdata_o[MASTER_BIT] && !wr_en_i && !master_kill_i)
    |=> !irq_o);

  a_r9_kill_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_kill_i |=> ((addr_i != SET_ADDR && addr_i != CLR_ADDR) || !rdata_o[MASTER_BIT]));

  a_r5_unmapped_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == SET_ADDR && !wr_en_i && !master_kill_i) |=>
    (addr_i != SET_ADDR || $stable(rdata_o)));
endmodule

bind irq_mask_reg irq_mask_reg_chk u_chk (.*);

// File: tb/irq_mask_reg_tb.sv
module irq_mask_reg_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = 8'h88;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] event_i = '0;
  logic        master_kill_i = 1'b0;
  logic        irq_o;

  int checks = 0;
  int fails = 0;
  bit m_on = 1'b0;

  // reference model state
  logic [31:0] ref_mask = '0;
  logic        ref_irq = 1'b0;
  localparam logic [31:0] IMPL = 32'hEFFF_83FF;

  always #5 clk_i = ~clk_i;

  irq_mask_reg u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model, advanced on every edge
  always @(posedge clk_i) begin
    if (rst_ni) begin
      logic [31:0] nm;
      ref_irq <= ref_mask[31] && ((ref_mask[30:0] & event_i[30:0]) != 0);
      nm = ref_mask;
      if (wr_en_i && addr_i == 8'h88) nm = nm | (wdata_i & IMPL);
      if (wr_en_i && addr_i == 8'h8C) nm = nm & ~wdata_i;
      if (master_kill_i) nm[31] = 1'b0;
      ref_mask <= nm;
    end
  end

  // compare on every clock, at the falling edge
  always @(negedge clk_i) begin
    if (m_on) begin
      logic [7:0] a;
      a = addr_i;
      chk("R7 irq", {31'b0, irq_o}, {31'b0, ref_irq});
      if (a == 8'h88 || a == 8'h8C) chk("R3 readback", rdata_o, ref_mask);
      else chk("R3 unmapped read", rdata_o, 32'h0);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic kill = 1'b0);
    @(posedge clk_i); #1;
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; master_kill_i = kill;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; master_kill_i = 1'b0; addr_i = 8'h88;
  endtask

  task automatic rd_both(input string req, input logic [31:0] exp);
    @(negedge clk_i);
    addr_i = 8'h88; #1; chk(req, rdata_o, exp);
    addr_i = 8'h8C; #1; chk(req, rdata_o, exp);
    addr_i = 8'h88;
  endtask

  initial begin
    fork
      begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk_i);
    #1;
    chk("R6 reset irq", {31'b0, irq_o}, 32'h0);
    chk("R6 reset mask", rdata_o, 32'h0);
    rst_ni = 1'b1;
    m_on = 1'b1;

    wr(8'h88, 32'hFFFF_FFFF);
    rd_both("R4 set all, rsvd zero", IMPL);
    wr(8'h8C, 32'h0000_FF00);
    rd_both("R2 clear subset", IMPL & ~32'h0000_FF00);
    wr(8'h88, 32'h0000_0300);
    rd_both("R1 set subset", (IMPL & ~32'h0000_FF00) | 32'h0000_0300);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h8D, 32'hFFFF_FFFF);
    rd_both("R5 unmapped write", (IMPL & ~32'h0000_FF00) | 32'h0000_0300);
    addr_i = 8'h44; #1; chk("R3 unmapped read", rdata_o, 32'h0); addr_i = 8'h88;

    // interrupt gating
    event_i = 32'h0000_0001;
    repeat (2) @(posedge clk_i); #1;
    chk("R7 irq asserted", {31'b0, irq_o}, 32'h1);
    wr(8'h8C, 32'h8000_0000);
    event_i = 32'h7FFF_FFFF;
    repeat (2) @(posedge clk_i); #1;
    chk("R8 master off", {31'b0, irq_o}, 32'h0);
    wr(8'h88, 32'h8000_0000);
    event_i = 32'h8000_0000;
    repeat (2) @(posedge clk_i); #1;
    chk("R7 event bit31 ignored", {31'b0, irq_o}, 32'h0);
    event_i = 32'h1000_0000;
    repeat (2) @(posedge clk_i); #1;
    chk("R4 bit28 event ignored", {31'b0, irq_o}, 32'h0);
    event_i = 32'h4000_0000;
    repeat (2) @(posedge clk_i); #1;
    chk("R7 bit30 source", {31'b0, irq_o}, 32'h1);

    // kill vs set in the same cycle
    wr(8'h88, 32'h8000_0000, 1'b1);
    rd_both("R9 kill beats set", ref_mask);
    chk("R9 bit31 low", {31'b0, rdata_o[31]}, 32'h0);
    repeat (2) @(posedge clk_i); #1;
    chk("R9 irq low after kill", {31'b0, irq_o}, 32'h0);

    // sweep of mixed patterns
    for (int i = 0; i < 40; i++) begin
      wr((i % 3 == 0) ? 8'h8C : 8'h88, 32'h9E37_79B9 * (i + 1));
      event_i = 32'h6A09_E667 ^ (i * 32'h0101_0101);
    end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule